// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

A general-purpose timer built around one shared time base. A clock source is picked from three: the system clock itself, an external edge pin, or channel 0's input pin. Its ticks go through a 16-bit prescaler into a 16-bit counter, which runs up, down or up/down between 0 and an auto-reload limit. Each period end raises a one-cycle update flag.

Four channels watch the shared counter. Each channel can run in one of four modes:
- capture: latch the counter on a rising input edge;
- compare: raise the output while the counter equals the channel value;
- PWM: raise the output while the counter is below the channel value;
- one-pulse: behave like PWM, but stop the counter at the next period end.

Software reaches all settings through a simple write port and a registered read port. The prescaler may be rewritten at any time. While the counter runs, a new prescaler value waits until the next period end, so the current period keeps its length.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter, all registers, the capture flags, `ch_out`, `upd` and `rd_data` are 0.
- R2: A counter step happens once every (active prescaler + 1) source ticks. A prescaler write made while running is applied at the next update event. While stopped, the active prescaler follows the written value and the counter holds, apart from direct writes.
- R3: In up mode (control field 0) the counter steps +1 and goes from the reload value (or above it) to 0, raising an update.
- R4: In down mode (control field 1) the counter steps -1 and goes from 0 to the reload value, raising an update.
- R5: In up/down mode (control field 2) the counter turns around at the reload value and at 0, and each turn raises an update. A write to the counter sets the direction to up.
- R6: `upd` is high for exactly one cycle per period end.
- R7: In PWM mode (channel code 2) a running channel drives high while counter < compare value. A value of 0 gives a constant low and a value above the reload gives a constant high.
- R8: In compare mode (channel code 1) a running channel drives high only while counter == compare value. Compare, PWM and one-pulse outputs are low while stopped.
- R9: In capture mode (channel code 0) a synchronized rising edge on `ch_in[i]` copies the counter into channel register i and sets sticky flag i. Writing 1 to status bit i clears the flag. Channels in other modes ignore their input.
- R10: If any channel is in one-pulse mode (code 3), the run bit clears at the update event, so exactly one compare-length pulse appears.
- R11: The clock source field selects the system clock (0), rising edges of `ext_clk` (1) or rising edges of `ch_in[0]` (2). Only the selected source advances the prescaler, and it advances once per edge.
- R12: Register map (4-bit address, 16-bit data):
  - 0 control: bit0 run, bits 2:1 count mode, bits 4:3 source.
  - 1 prescaler.
  - 2 reload.
  - 3 channel modes: 2 bits per channel, channel i at bits 2i+1:2i.
  - 4 to 7 channel values 0 to 3.
  - 8 status: capture flags in bits 3:0, write 1 to clear.
  - 9 counter, read and write.

  `rd_data` shows the addressed register one cycle after `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Registered read data |
| ext_clk | input | 1 | External edge clock source |
| ch_in | input | 4 | Channel input pins |
| ch_out | output | 4 | Channel output pins |
| upd | output | 1 | One-cycle update event flag |

## Verification
The bound checker watches every cycle for several rules:
- the landing value after each kind of period end;
- the counter standing still while stopped;
- the run bit clearing when one-pulse mode ends a period;
- constant-low outputs for a zero PWM value or a stopped compare channel;
- capture flags rising only on channels set to capture.

Other behaviours only the bench scenarios can show. These are the prescaler change that is held back until the period boundary, the PWM and compare duty over a full period, the single pulse length, source selection between pins, and the write-one clearing of flags. The bench drives the external edges itself, so counter positions can be predicted exactly.

// File: rtl/cc_timer_pkg.sv
`timescale 1ns/1ps
package cc_timer_pkg;
  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_PSC  = 1;
  localparam int A_ARR  = 2;
  localparam int A_CHM  = 3;
  localparam int A_CCR0 = 4;
  localparam int A_STAT = 8;
  localparam int A_CNT  = 9;

  // count modes
  localparam logic [1:0] CM_UP   = 2'd0;
  localparam logic [1:0] CM_DOWN = 2'd1;
  localparam logic [1:0] CM_UPDN = 2'd2;

  // clock sources
  localparam logic [1:0] SRC_INT = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
  localparam logic [1:0] SRC_CH0 = 2'd2;

  // channel modes
  localparam logic [1:0] CH_CAP = 2'd0;
  localparam logic [1:0] CH_CMP = 2'd1;
  localparam logic [1:0] CH_PWM = 2'd2;
  localparam logic [1:0] CH_OPM = 2'd3;
endpackage

// File: rtl/cct_sync_edge.sv
`timescale 1ns/1ps
module cct_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] st [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
      prev <= '0;
    end else begin
      st[0] <= din;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      prev <= st[STAGES-1];
    end
  end

  assign rise = st[STAGES-1] & ~prev;
endmodule

// File: rtl/cct_timebase.sv
`timescale 1ns/1ps
module cct_timebase
  import cc_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          src_pulse,
  input  logic [1:0]    cmode,
  input  logic [DW-1:0] psc_pre,
  input  logic [DW-1:0] arr,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wdata,
  output logic [DW-1:0] cnt,
  output logic          upd,
  output logic          wrap
);
  logic [DW-1:0] psc_act, psc_cnt, nxt;
  logic          dir, dir_n, at_end, tick;

  assign tick = run && src_pulse && (psc_cnt >= psc_act);

  // next counter value and period-end detection per count mode
  always_comb begin
    dir_n  = dir;
    at_end = 1'b0;
    nxt    = cnt;
    case (cmode)
      CM_DOWN: begin
        at_end = (cnt == '0);
        nxt    = at_end ? arr : cnt - 1'b1;
      end
      CM_UPDN: begin
        if (!dir) begin
          if (cnt >= arr) begin
            at_end = 1'b1;
            dir_n  = 1'b1;
            nxt    = (arr == '0) ? '0 : arr - 1'b1;
          end else begin
            nxt = cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            at_end = 1'b1;
            dir_n  = 1'b0;
            nxt    = (arr == '0) ? '0 : DW'(1);
          end else begin
            nxt = cnt - 1'b1;
          end
        end
      end
      default: begin
        at_end = (cnt >= arr);
        nxt    = at_end ? '0 : cnt + 1'b1;
      end
    endcase
  end

  assign wrap = tick && at_end && !cnt_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_act <= '0;
      psc_cnt <= '0;
      cnt     <= '0;
      dir     <= 1'b0;
      upd     <= 1'b0;
    end else begin
      upd <= wrap;
      if (!run) begin
        psc_act <= psc_pre;
        psc_cnt <= '0;
      end else begin
        if (src_pulse) psc_cnt <= (psc_cnt >= psc_act) ? '0 : psc_cnt + 1'b1;
        if (wrap) psc_act <= psc_pre;
      end
      if (cnt_wr) begin
        cnt <= cnt_wdata;
        dir <= 1'b0;
      end else if (tick) begin
        cnt <= nxt;
        dir <= dir_n;
      end
    end
  end
endmodule

// File: rtl/cct_channel.sv
`timescale 1ns/1ps
module cct_channel
  import cc_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          run,
  input  logic [DW-1:0] cnt,
  input  logic          val_wr,
  input  logic [DW-1:0] val_wdata,
  input  logic          cap_rise,
  input  logic          flag_clr,
  output logic [DW-1:0] val,
  output logic          flag,
  output logic          out
);
  logic cap_hit;
  assign cap_hit = (mode == CH_CAP) && cap_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      val  <= '0;
      flag <= 1'b0;
      out  <= 1'b0;
    end else begin
      if (val_wr)       val <= val_wdata;
      else if (cap_hit) val <= cnt;

      if (cap_hit)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      case (mode)
        CH_CMP:  out <= run && (cnt == val);
        CH_PWM,
        CH_OPM:  out <= run && (cnt < val);
        default: out <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cc_timer.sv
`timescale 1ns/1ps
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NCH  = 4,
  parameter int SYNC = 2,
  parameter int AW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           ext_clk,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] ch_out,
  output logic           upd
);
  localparam int MW = 2 * NCH;

  logic           run_q;
  logic [1:0]     cmode_q, src_q;
  logic [DW-1:0]  psc_pre_q, arr_q, cnt_q;
  logic [MW-1:0]  chm_q;
  logic [NCH*DW-1:0] ccr_flat;
  logic [NCH-1:0] cap_flag;
  logic [NCH:0]   rise;
  logic           src_pulse, wrap, op_any;
  logic           wr_ctrl, wr_psc, wr_arr, wr_chm, wr_stat, wr_cnt;
  logic [DW-1:0]  rd_mux;

  // input synchronizers: bit 0 external clock, bits NCH:1 channel pins
  cct_sync_edge #(.W(NCH+1), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .din({ch_in, ext_clk}), .rise(rise)
  );

  always_comb begin
    case (src_q)
      SRC_INT: src_pulse = 1'b1;
      SRC_EXT: src_pulse = rise[0];
      SRC_CH0: src_pulse = rise[1];
      default: src_pulse = 1'b0;
    endcase
  end

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_psc  = wr_en && (wr_addr == AW'(A_PSC));
  assign wr_arr  = wr_en && (wr_addr == AW'(A_ARR));
  assign wr_chm  = wr_en && (wr_addr == AW'(A_CHM));
  assign wr_stat = wr_en && (wr_addr == AW'(A_STAT));
  assign wr_cnt  = wr_en && (wr_addr == AW'(A_CNT));

  always_comb begin
    op_any = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (chm_q[2*i +: 2] == CH_OPM) op_any = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      cmode_q   <= CM_UP;
      src_q     <= SRC_INT;
      psc_pre_q <= '0;
      arr_q     <= '0;
      chm_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q   <= wr_data[0];
        cmode_q <= wr_data[2:1];
        src_q   <= wr_data[4:3];
      end
      // one-pulse stop wins over a simultaneous control write
      if (wrap && op_any) run_q <= 1'b0;
      if (wr_psc) psc_pre_q <= wr_data;
      if (wr_arr) arr_q     <= wr_data;
      if (wr_chm) chm_q     <= wr_data[MW-1:0];
    end
  end

  cct_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst(rst), .run(run_q), .src_pulse(src_pulse),
    .cmode(cmode_q), .psc_pre(psc_pre_q), .arr(arr_q),
    .cnt_wr(wr_cnt), .cnt_wdata(wr_data),
    .cnt(cnt_q), .upd(upd), .wrap(wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic val_wr;
    assign val_wr = wr_en && (wr_addr == AW'(A_CCR0 + g));
    cct_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .mode(chm_q[2*g +: 2]), .run(run_q),
      .cnt(cnt_q), .val_wr(val_wr), .val_wdata(wr_data),
      .cap_rise(rise[g+1]), .flag_clr(wr_stat && wr_data[g]),
      .val(ccr_flat[g*DW +: DW]), .flag(cap_flag[g]), .out(ch_out[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      AW'(A_CTRL): rd_mux = DW'({src_q, cmode_q, run_q});
      AW'(A_PSC):  rd_mux = psc_pre_q;
      AW'(A_ARR):  rd_mux = arr_q;
      AW'(A_CHM):  rd_mux = DW'(chm_q);
      AW'(A_STAT): rd_mux = DW'(cap_flag);
      AW'(A_CNT):  rd_mux = cnt_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (rd_addr == AW'(A_CCR0 + i)) rd_mux = ccr_flat[i*DW +: DW];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/cc_timer_chk.sv
`timescale 1ns/1ps
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              upd,
  input logic              run_q,
  input logic              op_any,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [1:0]        cmode_q,
  input logic [DW-1:0]     cnt_q,
  input logic [DW-1:0]     arr_q,
  input logic [2*NCH-1:0]  chm_q,
  input logic [NCH*DW-1:0] ccr_flat,
  input logic [NCH-1:0]    cap_flag,
  input logic [NCH-1:0]    ch_out
);
  // R3: up-mode period end lands on zero
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (upd && $past(cmode_q) == CM_UP) |-> cnt_q == '0);

  // R4: down-mode period end lands on the reload value
  p_down_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (upd && $past(cmode_q) == CM_DOWN) |-> cnt_q == $past(arr_q));

  // R5: up/down turn at zero steps to one
  p_updn_low_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && $past(cmode_q) == CM_UPDN && $past(cnt_q) == '0 && $past(arr_q) != '0)
      |-> cnt_q == DW'(1));

  // R2: a stopped counter only changes by a direct write
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(wr_en && wr_addr == AW'(A_CNT))) |=> $stable(cnt_q));

  // R10: one-pulse mode stops the counter at the period end
  p_one_pulse_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (upd && $past(op_any)) |-> !run_q);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R7: zero PWM value keeps the output low
    p_pwm_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (chm_q[2*g +: 2] == CH_PWM && ccr_flat[g*DW +: DW] == '0) |=> !ch_out[g]);

    // R8: stopped compare channel stays low
    p_cmp_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (chm_q[2*g +: 2] == CH_CMP && !run_q) |=> !ch_out[g]);

    // R9: flags rise only on capture-mode channels
    p_cap_only_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_flag[g]) |-> $past(chm_q[2*g +: 2]) == CH_CAP);
  end
endmodule

bind cc_timer cc_timer_chk #(.DW(DW), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .run_q(run_q), .op_any(op_any),
  .wr_en(wr_en), .wr_addr(wr_addr), .cmode_q(cmode_q), .cnt_q(cnt_q),
  .arr_q(arr_q), .chm_q(chm_q), .ccr_flat(ccr_flat), .cap_flag(cap_flag),
  .ch_out(ch_out)
);

// File: tb/cc_timer_bench.sv
`timescale 1ns/1ps
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ext_clk = 1'b0;
  logic [3:0]  ch_in = '0;
  logic [3:0]  ch_out;
  logic        upd;

  int n_chk = 0, n_fail = 0, upd_seen = 0;
  int    exp_q[$];
  string tag_q[$];
  event  ev_rd;

  always #2.5 clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk), .ch_in(ch_in),
    .ch_out(ch_out), .upd(upd)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read data and compares
  initial begin
    forever begin
      @(ev_rd);
      @(posedge clk);
      #1;
      check(tag_q.pop_front(), int'(rd_data), exp_q.pop_front());
    end
  end

  always @(negedge clk) if (!rst && upd) upd_seen++;

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected item, then issues the read
  task automatic rd_chk(int a, int exp, string tag);
    @(negedge clk);
    rd_addr = 4'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ->ev_rd;
    @(negedge clk);
  endtask

  task automatic ext_edges(int n);
    for (int k = 0; k < n; k++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic ch_edges(int i, int n);
    for (int k = 0; k < n; k++) begin
      ch_in[i] = 1'b1; repeat (4) @(negedge clk);
      ch_in[i] = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic high_count(int i, int ncyc, output int h);
    h = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (ch_out[i]) h++;
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk(9, 0, "R1 counter");
    rd_chk(0, 0, "R1 control");
    rd_chk(8, 0, "R1 status");
    check("R1 ch_out", int'(ch_out), 0);
    check("R1 upd", upd_seen, 0);

    // R3 / R11 up mode on external edges
    wr(2, 5);
    wr(0, 'h09);
    ext_edges(3);
    rd_chk(9, 3, "R11 ext edges counted");
    ext_edges(3);
    rd_chk(9, 0, "R3 wrap to zero");
    check("R6 one upd cycle", upd_seen, 1);

    // R2 prescaler written while running waits for the update
    wr(1, 2);
    ext_edges(5);
    rd_chk(9, 5, "R2 old prescaler kept");
    ext_edges(1);
    rd_chk(9, 0, "R2 wrap");
    check("R6 upd count", upd_seen, 2);
    ext_edges(2);
    rd_chk(9, 0, "R2 new prescaler holds");
    ext_edges(1);
    rd_chk(9, 1, "R2 new prescaler steps");
    wr(0, 'h08);
    wr(1, 0);
    ext_edges(2);
    rd_chk(9, 1, "R2 stopped counter holds");

    // R4 down mode
    wr(9, 2);
    wr(0, 'h0B);
    ext_edges(2);
    rd_chk(9, 0, "R4 count down");
    ext_edges(1);
    rd_chk(9, 5, "R4 reload on underflow");
    check("R4 upd", upd_seen, 3);

    // R5 up/down mode
    wr(0, 'h08);
    wr(2, 3);
    wr(9, 0);
    wr(0, 'h0D);
    ext_edges(4);
    rd_chk(9, 2, "R5 turn at top");
    check("R5 upd top", upd_seen, 4);
    ext_edges(3);
    rd_chk(9, 1, "R5 turn at bottom");
    check("R5 upd bottom", upd_seen, 5);

    // R11 channel-0 pin as clock source
    wr(0, 'h10);
    wr(9, 0);
    wr(0, 'h11);
    ext_edges(2);
    rd_chk(9, 0, "R11 unselected source ignored");
    ch_edges(0, 2);
    rd_chk(9, 2, "R11 ch0 source counted");

    // R9 capture
    wr(0, 0);
    wr(8, 'hF);
    rd_chk(8, 0, "R9 flags cleared");
    wr(9, 37);
    wr(3, 'h20);
    ch_edges(2, 1);
    rd_chk(8, 0, "R9 pwm channel ignores input flag");
    rd_chk(6, 0, "R9 pwm channel value untouched");
    ch_edges(3, 1);
    rd_chk(7, 37, "R9 captured value");
    rd_chk(8, 8, "R9 sticky flag");
    wr(8, 8);
    rd_chk(8, 0, "R9 write one clears");

    // R7 / R8 PWM and compare on internal clock
    wr(2, 9);
    wr(9, 0);
    wr(3, 'h18);
    wr(4 + 1, 4);
    wr(4 + 2, 7);
    wr(0, 'h01);
    repeat (5) @(negedge clk);
    high_count(1, 10, h); check("R7 pwm duty", h, 4);
    high_count(2, 10, h); check("R8 compare match width", h, 1);
    wr(5, 0);
    repeat (3) @(negedge clk);
    high_count(1, 10, h); check("R7 zero value low", h, 0);
    wr(5, 12);
    repeat (3) @(negedge clk);
    high_count(1, 10, h); check("R7 above reload high", h, 10);
    wr(0, 0);
    repeat (3) @(negedge clk);
    check("R8 stopped outputs low", int'(ch_out), 0);

    // R10 one-pulse
    wr(2, 7);
    wr(9, 0);
    wr(5, 3);
    wr(3, 'h0C);
    wr(0, 'h01);
    high_count(1, 40, h);
    check("R10 single pulse length", h, 3);
    rd_chk(0, 0, "R10 run cleared");
    rd_chk(9, 0, "R10 counter parked");

    // R12 readback
    rd_chk(2, 7, "R12 reload readback");
    rd_chk(3, 'h0C, "R12 mode readback");
    rd_chk(5, 3, "R12 channel value readback");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule